// File: doc/BRIEF.md
# SONET Section Overhead Inserter and Frame Scrambler

This block sits at the end of a SONET transmit path, just before serialization. It receives one byte per clock. The incoming stream already carries line overhead and payload. A frame-start strobe marks the first byte of each frame. The block overwrites the section overhead columns of the first three rows:

- the framing bytes;
- the STS identification bytes;
- the section parity byte;
- the remaining section bytes, which are forced to zero.

It then applies the frame-synchronous scrambler to every byte except the framing and identification bytes. A rate select input chooses between the single-STS frame (9 rows of 90 bytes) and the three-way interleaved concatenated frame (9 rows of 270 bytes). A scrambler enable input can bypass scrambling.

The section parity is an even BIP-8 over the transmitted (scrambled) bytes of one frame. It is inserted, before scrambling, into the next frame. A local position counter follows the frame. It restarts on every frame-start strobe and wraps by itself at the end of a frame when no strobe arrives. Output is registered with one cycle of latency. An aligned start-of-frame flag comes out with the data.

Top module: `soh_inserter`

## Requirements
- R1: On reset, `out_byte` is 00h and `out_sof` is 0. Until the first `frame_start` after reset, every output byte is 00h.
- R2: Let N be 1 when `rate_sel`=0 and 3 when `rate_sel`=1. In row 1, the first N bytes are output as F6h and the next N bytes as 28h, never scrambled.
- R3: In row 1, the N bytes following the 28h bytes carry the values 01h, 02h, ... N in order of appearance, never scrambled.
- R4: The byte at row 2, column 1 carries, before scrambling, the XOR of every output byte from the previous `frame_start` byte up to the byte before the latest `frame_start`. It is 00h in the first frame after reset.
- R5: All other bytes in columns 1..3N of rows 1 to 3 are 00h before scrambling.
- R6: All bytes outside those section overhead columns pass `in_byte` through, scrambled when `scr_en`=1.
- R7: Scrambling XORs each byte with the output of the x^7+x^6+1 generator, MSB first. The generator is loaded with all ones on row 1, column 3N+1, so that byte's key is FEh. It then advances 8 bits per byte through the rest of the frame.
- R8: When `scr_en`=0, no byte is scrambled. Section parity is still computed over the output bytes.
- R9: A `frame_start` at any byte restarts the frame position at row 1, column 1. Without a strobe, the position wraps to row 1, column 1 after row 9, column 90N, and the whole overhead sequence repeats.
- R10: `out_byte` and `out_sof` follow the input by exactly one clock. `out_sof` is 1 only for the byte that came with `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High with the first byte of a frame |
| rate_sel | input | 1 | 0: single STS frame, 1: three-way concatenated frame |
| scr_en | input | 1 | 1 enables the frame scrambler |
| in_byte | input | 8 | Incoming byte with line overhead and payload |
| out_byte | output | 8 | Transmit byte, one cycle after input |
| out_sof | output | 1 | Marks the output byte that carried frame_start |

## Verification
The assertions take for granted that `rate_sel` changes only together with `frame_start`, since the frame position is meaningless if the row length moves mid-frame. The stimulus changes rate only on the first byte of a frame. It also holds every input steady between the driving falling edges, so each byte sees one rate and one scrambler setting. Early restarts and strobe-free frames are driven deliberately; the assumption still holds because the rate is left unchanged across them.

// File: rtl/soh_ins_pkg.sv
package soh_ins_pkg;

    typedef enum logic {
        RATE_STS1  = 1'b0,
        RATE_STS3C = 1'b1
    } rate_e;

    typedef enum logic [2:0] {
        POS_A1   = 3'd0,
        POS_A2   = 3'd1,
        POS_C1   = 3'd2,
        POS_B1   = 3'd3,
        POS_ZERO = 3'd4,
        POS_DATA = 3'd5
    } pos_kind_e;

    typedef struct packed {
        pos_kind_e  kind;
        logic       scr_load;
        logic [1:0] c1_num;
    } pos_info_t;

    localparam logic [7:0] A1_CODE = 8'hF6;
    localparam logic [7:0] A2_CODE = 8'h28;

    localparam int SCR_W = 7;
    localparam logic [SCR_W-1:0] SCR_SEED = '1;

    // Key byte for a generator state, first generated bit in the MSB.
    function automatic logic [7:0] scr_key(input logic [SCR_W-1:0] s);
        logic [SCR_W-1:0] t;
        logic [7:0]       k;
        t = s;
        k = '0;
        for (int i = 7; i >= 0; i--) begin
            k[i] = t[SCR_W-1];
            t    = {t[SCR_W-2:0], t[SCR_W-1] ^ t[SCR_W-2]};
        end
        return k;
    endfunction

    // Generator state after eight steps.
    function automatic logic [SCR_W-1:0] scr_next(input logic [SCR_W-1:0] s);
        logic [SCR_W-1:0] t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = {t[SCR_W-2:0], t[SCR_W-1] ^ t[SCR_W-2]};
        end
        return t;
    endfunction

    function automatic logic is_framing(input pos_kind_e k);
        return (k == POS_A1) || (k == POS_A2) || (k == POS_C1);
    endfunction

endpackage

// File: rtl/soh_frame_pos.sv
module soh_frame_pos
    import soh_ins_pkg::*;
#(
    parameter int ROWS         = 9,
    parameter int COLS_PER_STS = 90,
    parameter int SOH_COLS     = 3,
    parameter int MAX_STS      = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_start,
    input  rate_e     rate_sel,
    output logic      locked,
    output pos_info_t info
);

    localparam int MAX_COLS = COLS_PER_STS * MAX_STS;
    localparam int COL_W    = $clog2(MAX_COLS);
    localparam int ROW_W    = $clog2(ROWS);

    logic [ROW_W-1:0] row_q, row_c;
    logic [COL_W-1:0] col_q, col_c;
    logic             lock_q;

    logic [COL_W-1:0] n_sts;
    logic [COL_W-1:0] col_last;
    logic [COL_W-1:0] a2_start;
    logic [COL_W-1:0] c1_start;
    logic [COL_W-1:0] soh_end;

    assign n_sts    = (rate_sel == RATE_STS3C) ? COL_W'(MAX_STS) : COL_W'(1);
    assign col_last = COL_W'(COLS_PER_STS) * n_sts - COL_W'(1);
    assign a2_start = n_sts;
    assign c1_start = n_sts + n_sts;
    assign soh_end  = COL_W'(SOH_COLS) * n_sts;
    assign locked   = lock_q | frame_start;

    // Position of the byte presented this cycle.
    always_comb begin
        if (frame_start) begin
            row_c = '0;
            col_c = '0;
        end else if (col_q >= col_last) begin
            col_c = '0;
            row_c = (int'(row_q) >= ROWS - 1) ? '0 : row_q + ROW_W'(1);
        end else begin
            col_c = col_q + COL_W'(1);
            row_c = row_q;
        end
    end

    // Classify the position.
    always_comb begin
        info.kind     = POS_DATA;
        info.scr_load = 1'b0;
        info.c1_num   = 2'd0;
        if (row_c == ROW_W'(0)) begin
            if (col_c < a2_start) begin
                info.kind = POS_A1;
            end else if (col_c < c1_start) begin
                info.kind = POS_A2;
            end else if (col_c < soh_end) begin
                info.kind   = POS_C1;
                info.c1_num = 2'(col_c - c1_start + COL_W'(1));
            end
            info.scr_load = (col_c == soh_end);
        end else if (row_c == ROW_W'(1)) begin
            if (col_c == '0) begin
                info.kind = POS_B1;
            end else if (col_c < soh_end) begin
                info.kind = POS_ZERO;
            end
        end else if (row_c == ROW_W'(2)) begin
            if (col_c < soh_end) begin
                info.kind = POS_ZERO;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            col_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            row_q  <= row_c;
            col_q  <= col_c;
            lock_q <= locked;
        end
    end

    AST_POS_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(row_q) < ROWS); // R9
    AST_POS_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(col_q) < MAX_COLS); // R9
    AST_FS_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (row_q == '0 && col_q == '0)); // R9
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q); // R1
    AST_RATE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !frame_start) |-> $stable(rate_sel)); // R2

endmodule

// File: rtl/soh_scrambler.sv
module soh_scrambler
    import soh_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       advance,
    output logic [7:0] key
);

    logic [SCR_W-1:0] state_q;
    logic [SCR_W-1:0] state_use;

    assign state_use = load ? SCR_SEED : state_q;
    assign key       = scr_key(state_use);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCR_SEED;
        end else if (advance) begin
            state_q <= scr_next(state_use);
        end
    end

    AST_SCR_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && advance) |=> (state_q == 7'h02)); // R7
    AST_SCR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R7

endmodule

// File: rtl/soh_bip8.sv
module soh_bip8 (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       locked,
    input  logic [7:0] tx_byte,
    output logic [7:0] b1
);

    logic [7:0] acc_q;
    logic [7:0] b1_q;

    assign b1 = b1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            b1_q  <= '0;
        end else if (frame_start) begin
            b1_q  <= acc_q;
            acc_q <= tx_byte;
        end else if (locked) begin
            acc_q <= acc_q ^ tx_byte;
        end
    end

    AST_B1_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !locked |=> (acc_q == '0 && b1_q == '0)); // R4
    AST_B1_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(b1_q)); // R4

endmodule

// File: rtl/soh_inserter.sv
module soh_inserter
    import soh_ins_pkg::*;
#(
    parameter int ROWS         = 9,
    parameter int COLS_PER_STS = 90,
    parameter int SOH_COLS     = 3,
    parameter int MAX_STS      = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       rate_sel,
    input  logic       scr_en,
    input  logic [7:0] in_byte,
    output logic [7:0] out_byte,
    output logic       out_sof
);

    rate_e      rate;
    logic       locked;
    pos_info_t  info;
    logic [7:0] key;
    logic [7:0] b1;
    logic [7:0] pre_byte;
    logic       scr_apply;
    logic [7:0] tx_next;

    assign rate = rate_e'(rate_sel);

    soh_frame_pos #(
        .ROWS         (ROWS),
        .COLS_PER_STS (COLS_PER_STS),
        .SOH_COLS     (SOH_COLS),
        .MAX_STS      (MAX_STS)
    ) u_pos (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .rate_sel    (rate),
        .locked      (locked),
        .info        (info)
    );

    soh_scrambler u_scr (
        .clk     (clk),
        .rst     (rst),
        .load    (locked && info.scr_load),
        .advance (locked),
        .key     (key)
    );

    soh_bip8 u_bip (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .locked      (locked),
        .tx_byte     (tx_next),
        .b1          (b1)
    );

    always_comb begin
        unique case (info.kind)
            POS_A1:   pre_byte = A1_CODE;
            POS_A2:   pre_byte = A2_CODE;
            POS_C1:   pre_byte = {6'b0, info.c1_num};
            POS_B1:   pre_byte = b1;
            POS_ZERO: pre_byte = 8'h00;
            default:  pre_byte = in_byte;
        endcase
    end

    assign scr_apply = scr_en && !is_framing(info.kind);
    assign tx_next   = locked ? (pre_byte ^ (scr_apply ? key : 8'h00)) : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_byte <= '0;
            out_sof  <= 1'b0;
        end else begin
            out_byte <= tx_next;
            out_sof  <= frame_start;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !locked |=> (out_byte == 8'h00)); // R1
    AST_A1_CODE: assert property (@(posedge clk) disable iff (rst)
        (locked && info.kind == POS_A1) |=> (out_byte == 8'hF6)); // R2
    AST_A2_CODE: assert property (@(posedge clk) disable iff (rst)
        (locked && info.kind == POS_A2) |=> (out_byte == 8'h28)); // R2
    AST_C1_RANGE: assert property (@(posedge clk) disable iff (rst)
        (locked && info.kind == POS_C1) |=>
            (out_byte != 8'h00 && out_byte <= 8'(MAX_STS))); // R3
    AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (locked && info.kind == POS_ZERO && !scr_en) |=> (out_byte == 8'h00)); // R5
    AST_DATA_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (locked && info.kind == POS_DATA && !scr_en) |=>
            (out_byte == $past(in_byte))); // R8
    AST_SOF_ALIGN: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> out_sof); // R10
    AST_SOF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> !out_sof); // R10

endmodule

// File: tb/soh_inserter_test.sv
`timescale 1ns/1ps
module soh_inserter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       rate_sel = 1'b0;
    logic       scr_en = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] out_byte;
    logic       out_sof;

    soh_inserter uut (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .rate_sel    (rate_sel),
        .scr_en      (scr_en),
        .in_byte     (in_byte),
        .out_byte    (out_byte),
        .out_sof     (out_sof)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    logic [7:0] exp_q[$];
    logic       sof_q[$];
    string      tag_q[$];

    // Reference model state
    int         m_row = 0;
    int         m_col = 0;
    bit         m_lock = 1'b0;
    logic [6:0] m_scr = 7'h7F;
    logic [7:0] m_acc = 8'h00;
    logic [7:0] m_b1 = 8'h00;
    int         m_data = 0;
    string      phase_tag = "";

    // x^7+x^6+1 generator, MSB first, eight steps per byte
    function automatic logic [7:0] m_key(input logic [6:0] s);
        logic [7:0] k;
        for (int i = 7; i >= 0; i--) begin
            k[i] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    function automatic logic [6:0] m_step(input logic [6:0] s);
        for (int i = 0; i < 8; i++) s = {s[5:0], s[6] ^ s[5]};
        return s;
    endfunction

    task automatic drive(input bit fs, input bit rate, input bit scr, input logic [7:0] d);
        int         n;
        logic [7:0] pre;
        logic [7:0] exp;
        bit         framing;
        string      tag;
        @(negedge clk);
        frame_start = fs;
        rate_sel    = rate;
        scr_en      = scr;
        in_byte     = d;
        n = rate ? 3 : 1;
        if (fs) begin
            m_b1   = m_acc;
            m_acc  = 8'h00;
            m_row  = 0;
            m_col  = 0;
            m_lock = 1'b1;
        end else begin
            m_col++;
            if (m_col == 90 * n) begin
                m_col = 0;
                m_row++;
                if (m_row == 9) m_row = 0;
            end
        end
        if (!m_lock) begin
            exp = 8'h00;
            tag = "R1 pre-lock";
        end else begin
            framing = 1'b0;
            if (m_row == 0 && m_col < n) begin
                pre = 8'hF6; framing = 1'b1; tag = "R2 A1";
            end else if (m_row == 0 && m_col < 2 * n) begin
                pre = 8'h28; framing = 1'b1; tag = "R2 A2";
            end else if (m_row == 0 && m_col < 3 * n) begin
                pre = 8'(m_col - 2 * n + 1); framing = 1'b1; tag = "R3 C1";
            end else if (m_row == 1 && m_col == 0) begin
                pre = m_b1; tag = "R4 B1";
            end else if (m_row < 3 && m_col < 3 * n) begin
                pre = 8'h00; tag = "R5 section zero";
            end else begin
                pre = d; tag = scr ? "R6 data" : "R8 unscrambled data";
            end
            if (m_row == 0 && m_col == 3 * n) begin
                m_scr = 7'h7F;
                if (scr) tag = "R7 scrambler seed";
            end
            exp = (scr && !framing) ? (pre ^ m_key(m_scr)) : pre;
            m_scr = m_step(m_scr);
            m_acc = m_acc ^ exp;
        end
        if (phase_tag != "") tag = {phase_tag, " ", tag};
        exp_q.push_back(exp);
        sof_q.push_back(fs);
        tag_q.push_back(tag);
    endtask

    task automatic send_frame(input bit use_fs, input bit rate, input bit scr, input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            drive(use_fs && (i == 0), rate, scr, 8'(m_data * 37 + 11));
            m_data++;
        end
    endtask

    // Monitor: compare each output byte against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                logic       es;
                string      t;
                e  = exp_q.pop_front();
                es = sof_q.pop_front();
                t  = tag_q.pop_front();
                checks++;
                if (out_byte !== e || out_sof !== es) begin
                    failures++;
                    $display("FAIL %s (sof: R10): byte actual=%02h expected=%02h sof actual=%0b expected=%0b",
                             t, out_byte, e, out_sof, es);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checks++;
        if (out_byte !== 8'h00 || out_sof !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: byte actual=%02h expected=00 sof actual=%0b expected=0",
                     out_byte, out_sof);
        end
        // R1: bytes before any frame start
        send_frame(1'b0, 1'b0, 1'b1, 20);
        // Single-STS frames, scrambled (R2..R7, R4 first-frame zero)
        repeat (3) send_frame(1'b1, 1'b0, 1'b1, 810);
        // Concatenated frames, scrambled, rate change on a frame start
        repeat (2) send_frame(1'b1, 1'b1, 1'b1, 2430);
        // R9: early restart, then a frame with no strobe (wrap)
        phase_tag = "R9";
        send_frame(1'b1, 1'b1, 1'b1, 500);
        send_frame(1'b1, 1'b1, 1'b1, 2430);
        send_frame(1'b0, 1'b1, 1'b1, 2430);
        phase_tag = "";
        send_frame(1'b1, 1'b1, 1'b1, 2430);
        // R8: scrambler off, both rates
        repeat (2) send_frame(1'b1, 1'b0, 1'b0, 810);
        send_frame(1'b1, 1'b1, 1'b0, 2430);
        send_frame(1'b1, 1'b1, 1'b1, 2430);
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R10 drain: pending actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule